// File: doc/BRIEF.md
# NAND Page Transfer Control Unit

This block is the register-facing control unit of a NAND flash controller. It launches a whole-page read or program and reports how that page ended. Software fills in the per-chip setup words (device setup, two timing words, transfer layout, first-packet and later-packet layout, bad-block marker placement), the page address and the column offset. It then writes a command word. A valid command drops the ready flag and hands the flash pads from raw mode to controller mode. It also pulses a start strobe toward the data path.

The data path reports one result per ECC packet on a small result interface. Each result carries an error count, a decode-success bit and an erased indication. The block counts these results against the step count that was latched at launch. When the last packet arrives it returns the pads to raw mode and raises ready again.

For reads, the per-packet results are folded into one error report word. The first packet keeps its exact count and its own success bit. The later packets share a single field that holds their largest count, and a single success bit that clears if any of them failed. A page where every packet was erased raises an erased flag, and the report then reads as clean.

Top module: `nand_xfer_ctl`

## Requirements
- R1: After reset, offset 0x00 reads 0x8000_0000 (bit 31 is ready), offset 0x30 (pad mode, bit 31 = controller mode) reads 0, offset 0x34 (error report) reads 0x0000_8080 and offset 0x2C (transfer status) reads 0; `pad_ctrl_mode` is 0.
- R2: The nine setup words at offsets 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24 and 0x28 read back the last value written to them. The command offset 0x04 always reads 0.
- R3: Writing 1 (read) or 2 (program) to offset 0x04 while ready starts a transfer. From the next cycle ready reads 0, pad mode bit 31 and `pad_ctrl_mode` are 1, and `xfer_start` is high for exactly that one cycle. `xfer_write` is 1 throughout a program and 0 throughout a read.
- R4: The step count is bits [15:8] of offset 0x14, latched at launch; a value of 0 behaves as 1. The transfer ends on the clock edge that samples the result of the last step. After that edge ready is 1 and the pads are back in raw mode. Rewriting offset 0x14 mid-transfer does not change the step count in use.
- R5: A command written while ready is 0, or any command value other than 1 or 2, is ignored. Packet results presented while ready is 1 are ignored.
- R6: Error report bits [5:0] hold the first packet's error count, saturated at 63. Bit 7 holds its decode success, where 0 means failure.
- R7: Error report bits [13:8] hold the largest saturated count among packets after the first. Bit 15 is 1 only if all of those packets decoded. Bits 6, 14 and [31:16] read 0. With a single step, the later-packet field reads count 0 with success 1.
- R8: Transfer status bit 16 is set after a read in which every packet reported erased. While it is set, the error report reads 0x0000_8080 regardless of the packet results.
- R9: A program transfer leaves the error report and transfer status as the previous read left them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| pkt_valid | input | 1 | One packet result is presented this cycle |
| pkt_err | input | 8 | Raw corrected-bit count of the packet |
| pkt_ok | input | 1 | Packet decoded successfully |
| pkt_erased | input | 1 | Packet was found erased |
| pad_ctrl_mode | output | 1 | Pads owned by controller (1) or raw access (0) |
| xfer_start | output | 1 | One-cycle launch strobe to the data path |
| xfer_write | output | 1 | Current transfer is a program |

## Verification
A register write takes effect on the edge that samples it, so a launching command shows up as ready 0 and a high `xfer_start` in the following cycle. The strobe falls one cycle after that. The final packet result moves ready, pad mode, the report and the erased flag on the edge that samples it. Register reads are combinational. The bench drives every input at the falling edge and checks the ports at the next falling edge. A scoreboard monitor takes expected register words from a queue and sets the read address at a falling edge. It compares the read data 2 ns later, and the driver waits for the queue to empty before it changes state again.

// File: rtl/nxc_pkg.sv
`timescale 1ns/1ps
package nxc_pkg;

    localparam int unsigned DW       = 32;
    localparam int unsigned AW       = 8;
    localparam int unsigned ERR_IN_W = 8;
    localparam int unsigned CNT_W    = 6;
    localparam int unsigned CNT_MAX  = (1 << CNT_W) - 1;
    localparam int unsigned STEP_W   = 8;
    localparam int unsigned NCFG     = 9;
    localparam int unsigned XCFG_IDX = 3;
    localparam int unsigned STEP_LSB = 8;

    localparam logic [AW-1:0] A_STATUS = 8'h00;
    localparam logic [AW-1:0] A_CMD    = 8'h04;
    localparam logic [AW-1:0] A_CFG0   = 8'h08;
    localparam logic [AW-1:0] A_XSTAT  = 8'h2C;
    localparam logic [AW-1:0] A_PAD    = 8'h30;
    localparam logic [AW-1:0] A_ERRRPT = 8'h34;

    localparam int unsigned ERASED_BIT = 16;
    localparam int unsigned FLAG_BIT   = 31;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic             n_ok;
        logic [CNT_W-1:0] n_cnt;
        logic             p0_ok;
        logic [CNT_W-1:0] p0_cnt;
    } ecc_rpt_t;

    function automatic ecc_rpt_t rpt_clean();
        ecc_rpt_t r;
        r.n_ok   = 1'b1;
        r.n_cnt  = '0;
        r.p0_ok  = 1'b1;
        r.p0_cnt = '0;
        return r;
    endfunction

    function automatic logic [DW-1:0] rpt_pack(ecc_rpt_t r);
        return {16'h0000, r.n_ok, 1'b0, r.n_cnt, r.p0_ok, 1'b0, r.p0_cnt};
    endfunction

    function automatic logic [CNT_W-1:0] sat_cnt(logic [ERR_IN_W-1:0] v);
        if (v > ERR_IN_W'(CNT_MAX)) return CNT_W'(CNT_MAX);
        return v[CNT_W-1:0];
    endfunction

    function automatic logic [AW-1:0] cfg_addr(int unsigned idx);
        return A_CFG0 + AW'(4 * idx);
    endfunction

endpackage

// File: rtl/nxc_regfile.sv
`timescale 1ns/1ps
module nxc_regfile
    import nxc_pkg::*;
#(
    parameter int unsigned N = NCFG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [AW-1:0]      waddr,
    input  logic [DW-1:0]      wdata,
    output logic [N-1:0][DW-1:0] cfg
);

    for (genvar i = 0; i < N; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i] <= '0;
            end else if (wr && waddr == cfg_addr(i)) begin
                cfg[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/nxc_seq.sv
`timescale 1ns/1ps
module nxc_seq
    import nxc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [DW-1:0]     cmd_val,
    input  logic [STEP_W-1:0] steps_cfg,
    input  logic              pkt_valid,
    output logic              busy,
    output logic              is_read,
    output logic              start_pulse,
    output logic              take,
    output logic              first_pkt,
    output logic              clear_rd,
    output logic [STEP_W-1:0] pkt_cnt,
    output logic [STEP_W-1:0] steps_lat
);

    logic launch;
    logic is_rd_cmd;
    logic is_wr_cmd;
    logic last_pkt;

    assign is_rd_cmd = (cmd_val == DW'(OP_READ));
    assign is_wr_cmd = (cmd_val == DW'(OP_WRITE));
    assign launch    = cmd_wr && !busy && (is_rd_cmd || is_wr_cmd);
    assign clear_rd  = launch && is_rd_cmd;
    assign take      = busy && pkt_valid;
    assign first_pkt = (pkt_cnt == '0);
    assign last_pkt  = (pkt_cnt == STEP_W'(steps_lat - STEP_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            is_read     <= 1'b0;
            start_pulse <= 1'b0;
            pkt_cnt     <= '0;
            steps_lat   <= STEP_W'(1);
        end else begin
            start_pulse <= launch;
            if (launch) begin
                busy      <= 1'b1;
                is_read   <= is_rd_cmd;
                pkt_cnt   <= '0;
                steps_lat <= (steps_cfg == '0) ? STEP_W'(1) : steps_cfg;
            end else if (take) begin
                if (last_pkt) begin
                    busy    <= 1'b0;
                    pkt_cnt <= '0;
                end else begin
                    pkt_cnt <= pkt_cnt + STEP_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/nxc_ecc_fold.sv
`timescale 1ns/1ps
module nxc_ecc_fold
    import nxc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                take,
    input  logic                first,
    input  logic [ERR_IN_W-1:0] err,
    input  logic                ok,
    input  logic                erased,
    output ecc_rpt_t            rpt,
    output logic                erased_flag
);

    logic [CNT_W-1:0] cnt_s;

    assign cnt_s = sat_cnt(err);

    always_ff @(posedge clk) begin
        if (rst) begin
            rpt         <= rpt_clean();
            erased_flag <= 1'b0;
        end else if (clear) begin
            rpt         <= rpt_clean();
            erased_flag <= 1'b1;
        end else if (take) begin
            erased_flag <= erased_flag & erased;
            if (first) begin
                rpt.p0_cnt <= cnt_s;
                rpt.p0_ok  <= ok;
            end else begin
                if (cnt_s > rpt.n_cnt) rpt.n_cnt <= cnt_s;
                rpt.n_ok <= rpt.n_ok & ok;
            end
        end
    end

endmodule

// File: rtl/nand_xfer_ctl.sv
`timescale 1ns/1ps
module nand_xfer_ctl
    import nxc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic [AW-1:0]       reg_waddr,
    input  logic [DW-1:0]       reg_wdata,
    input  logic [AW-1:0]       reg_raddr,
    output logic [DW-1:0]       reg_rdata,
    input  logic                pkt_valid,
    input  logic [ERR_IN_W-1:0] pkt_err,
    input  logic                pkt_ok,
    input  logic                pkt_erased,
    output logic                pad_ctrl_mode,
    output logic                xfer_start,
    output logic                xfer_write
);

    logic [NCFG-1:0][DW-1:0] cfg;
    logic              busy;
    logic              is_read;
    logic              take;
    logic              first_pkt;
    logic              clear_rd;
    logic [STEP_W-1:0] pkt_cnt;
    logic [STEP_W-1:0] steps_lat;
    ecc_rpt_t          rpt;
    ecc_rpt_t          rpt_view;
    logic              erased_flag;

    nxc_regfile #(.N(NCFG)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .waddr (reg_waddr),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    nxc_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (reg_wr && reg_waddr == A_CMD),
        .cmd_val     (reg_wdata),
        .steps_cfg   (cfg[XCFG_IDX][STEP_LSB +: STEP_W]),
        .pkt_valid   (pkt_valid),
        .busy        (busy),
        .is_read     (is_read),
        .start_pulse (xfer_start),
        .take        (take),
        .first_pkt   (first_pkt),
        .clear_rd    (clear_rd),
        .pkt_cnt     (pkt_cnt),
        .steps_lat   (steps_lat)
    );

    nxc_ecc_fold u_fold (
        .clk         (clk),
        .rst         (rst),
        .clear       (clear_rd),
        .take        (take && is_read),
        .first       (first_pkt),
        .err         (pkt_err),
        .ok          (pkt_ok),
        .erased      (pkt_erased),
        .rpt         (rpt),
        .erased_flag (erased_flag)
    );

    assign pad_ctrl_mode = busy;
    assign xfer_write    = busy && !is_read;
    assign rpt_view      = erased_flag ? rpt_clean() : rpt;

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            A_STATUS: reg_rdata[FLAG_BIT]   = !busy;
            A_XSTAT:  reg_rdata[ERASED_BIT] = erased_flag;
            A_PAD:    reg_rdata[FLAG_BIT]   = busy;
            A_ERRRPT: reg_rdata             = rpt_pack(rpt_view);
            default: begin
                for (int i = 0; i < NCFG; i++) begin
                    if (reg_raddr == cfg_addr(i)) reg_rdata = cfg[i];
                end
            end
        endcase
    end

endmodule

// File: rtl/nxc_checker.sv
`timescale 1ns/1ps
module nxc_checker
    import nxc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic                xfer_start,
    input logic                take_rd,
    input logic                first,
    input logic                clear_rd,
    input logic [ERR_IN_W-1:0] pkt_err,
    input logic [STEP_W-1:0]   pkt_cnt,
    input logic [STEP_W-1:0]   steps_lat,
    input ecc_rpt_t            rpt
);

    // R3: the launch strobe only appears while a transfer is active
    a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> busy);

    // R4: packet counter never passes the latched step count
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pkt_cnt < steps_lat));

    // R4, R5: step count stays fixed during a running transfer
    a_r5_steps_hold: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(steps_lat)));

    // R6: a large first-packet count lands saturated
    a_r6_sat_first: assert property (@(posedge clk) disable iff (rst)
        (take_rd && first && pkt_err >= ERR_IN_W'(CNT_MAX)) |=> (rpt.p0_cnt == CNT_W'(CNT_MAX)));

    // R7: later-packet field only grows within a read
    a_r7_max_grow: assert property (@(posedge clk) disable iff (rst)
        (take_rd && !first) |=> (rpt.n_cnt >= $past(rpt.n_cnt)));

    // R7: a later-packet failure persists until the next read launch
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (!clear_rd && !rpt.n_ok) |=> !rpt.n_ok);

endmodule

bind nand_xfer_ctl nxc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .xfer_start (xfer_start),
    .take_rd    (take && is_read),
    .first      (first_pkt),
    .clear_rd   (clear_rd),
    .pkt_err    (pkt_err),
    .pkt_cnt    (pkt_cnt),
    .steps_lat  (steps_lat),
    .rpt        (rpt)
);

// File: tb/nand_xfer_ctl_test.sv
`timescale 1ns/1ps
module nand_xfer_ctl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        pkt_valid = 1'b0;
    logic [7:0]  pkt_err = '0;
    logic        pkt_ok = 1'b0;
    logic        pkt_erased = 1'b0;
    logic        pad_ctrl_mode;
    logic        xfer_start;
    logic        xfer_write;

    always #10 clk = ~clk;

    nand_xfer_ctl uut (
        .clk           (clk),
        .rst           (rst),
        .reg_wr        (reg_wr),
        .reg_waddr     (reg_waddr),
        .reg_wdata     (reg_wdata),
        .reg_raddr     (reg_raddr),
        .reg_rdata     (reg_rdata),
        .pkt_valid     (pkt_valid),
        .pkt_err       (pkt_err),
        .pkt_ok        (pkt_ok),
        .pkt_erased    (pkt_erased),
        .pad_ctrl_mode (pad_ctrl_mode),
        .xfer_start    (xfer_start),
        .xfer_write    (xfer_write)
    );

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    mon_busy = 1'b0;
    bit    finished = 1'b0;

    localparam logic [31:0] READY = 32'h8000_0000;
    localparam logic [31:0] CLEAN = 32'h0000_8080;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rpt(int c0, bit o0, int cn, bit on);
        return {16'h0, on, 1'b0, 6'(cn), o0, 1'b0, 6'(c0)};
    endfunction

    task automatic expect_rd(logic [7:0] a, logic [31:0] e, string tag);
        item_t it;
        it.addr = a;
        it.exp  = e;
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic drain();
        wait (q.size() == 0 && !mon_busy);
    endtask

    // monitor: pops expected register words and compares
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                mon_busy = 1'b1;
                it = q.pop_front();
                reg_raddr = it.addr;
                #2;
                chk(it.tag, reg_rdata, it.exp);
                mon_busy = 1'b0;
            end
        end
    end

    task automatic wreg(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_waddr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pkt(int e, bit ok, bit er);
        @(negedge clk);
        pkt_valid = 1'b1;
        pkt_err = 8'(e);
        pkt_ok = ok;
        pkt_erased = er;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 pad port", {31'b0, pad_ctrl_mode}, 32'h0);
        expect_rd(8'h00, READY, "R1 status");
        expect_rd(8'h30, 32'h0, "R1 pad reg");
        expect_rd(8'h34, CLEAN, "R1 report");
        expect_rd(8'h2C, 32'h0, "R1 xstat");
        drain();

        // R2 setup readback, command reads zero, R5 bad command ignored
        wreg(8'h14, 32'h0201_0404);
        wreg(8'h08, 32'hA5A5_0001);
        wreg(8'h18, 32'h0204_0008);
        wreg(8'h28, 32'h0000_0123);
        wreg(8'h04, 32'h0000_0003);
        expect_rd(8'h14, 32'h0201_0404, "R2 xfer cfg");
        expect_rd(8'h08, 32'hA5A5_0001, "R2 dev cfg");
        expect_rd(8'h18, 32'h0204_0008, "R2 pkt0 cfg");
        expect_rd(8'h28, 32'h0000_0123, "R2 column");
        expect_rd(8'h04, 32'h0, "R2 cmd reads zero");
        expect_rd(8'h00, READY, "R5 bad cmd ignored");
        drain();
        chk("R5 bad cmd no pads", {31'b0, pad_ctrl_mode}, 32'h0);

        // R3 read launch, 4 steps
        wreg(8'h04, 32'h1);
        chk("R3 start pulse", {31'b0, xfer_start}, 32'h1);
        chk("R3 read dir", {31'b0, xfer_write}, 32'h0);
        chk("R3 pad port", {31'b0, pad_ctrl_mode}, 32'h1);
        expect_rd(8'h00, 32'h0, "R3 busy status");
        expect_rd(8'h30, READY, "R3 pad reg");
        drain();
        chk("R3 start one cycle", {31'b0, xfer_start}, 32'h0);
        pkt(3, 1, 0);
        pkt(5, 1, 0);
        wreg(8'h04, 32'h2);
        chk("R5 cmd while busy dir", {31'b0, xfer_write}, 32'h0);
        chk("R5 cmd while busy strobe", {31'b0, xfer_start}, 32'h0);
        pkt(2, 1, 0);
        expect_rd(8'h00, 32'h0, "R4 not done before last");
        drain();
        pkt(7, 1, 0);
        chk("R4 pads raw at end", {31'b0, pad_ctrl_mode}, 32'h0);
        expect_rd(8'h00, READY, "R4 ready at end");
        expect_rd(8'h34, rpt(3, 1, 7, 1), "R6 R7 clean read");
        expect_rd(8'h2C, 32'h0, "R8 not erased");
        drain();

        // R6 R7 saturation and later-packet failure
        wreg(8'h04, 32'h1);
        pkt(200, 1, 0);
        pkt(70, 0, 0);
        pkt(1, 1, 0);
        pkt(0, 1, 0);
        expect_rd(8'h34, rpt(63, 1, 63, 0), "R6 R7 saturate and fail");
        drain();

        // R6 first-packet failure
        wreg(8'h04, 32'h1);
        pkt(10, 0, 0);
        pkt(1, 1, 0);
        pkt(2, 1, 0);
        pkt(2, 1, 0);
        expect_rd(8'h34, rpt(10, 0, 2, 1), "R6 first fails");
        drain();

        // R8 fully erased page
        wreg(8'h04, 32'h1);
        for (int i = 0; i < 4; i++) pkt(5, 0, 1);
        expect_rd(8'h2C, 32'h0001_0000, "R8 erased flag");
        expect_rd(8'h34, CLEAN, "R8 clean report");
        drain();

        // R8 partly erased page
        wreg(8'h04, 32'h1);
        pkt(1, 1, 1);
        pkt(2, 1, 0);
        pkt(0, 1, 1);
        pkt(0, 1, 1);
        expect_rd(8'h2C, 32'h0, "R8 partial not erased");
        expect_rd(8'h34, rpt(1, 1, 2, 1), "R8 partial report");
        drain();

        // R9 program leaves report alone
        wreg(8'h04, 32'h2);
        chk("R3 write dir", {31'b0, xfer_write}, 32'h1);
        for (int i = 0; i < 4; i++) pkt(9, 0, 1);
        expect_rd(8'h00, READY, "R9 write done");
        expect_rd(8'h34, rpt(1, 1, 2, 1), "R9 report kept");
        expect_rd(8'h2C, 32'h0, "R9 xstat kept");
        drain();
        chk("R3 write dir cleared", {31'b0, xfer_write}, 32'h0);

        // R4 R7 zero steps acts as one
        wreg(8'h14, 32'h0000_0004);
        wreg(8'h04, 32'h1);
        pkt(4, 1, 0);
        expect_rd(8'h00, READY, "R4 zero steps single");
        expect_rd(8'h34, rpt(4, 1, 0, 1), "R7 single step");
        drain();

        // R5 results ignored while idle
        pkt(50, 0, 1);
        expect_rd(8'h34, rpt(4, 1, 0, 1), "R5 idle pkt ignored");
        expect_rd(8'h00, READY, "R5 idle stays ready");
        drain();

        // R4 step count latched at launch
        wreg(8'h14, 32'h0000_0200);
        wreg(8'h04, 32'h1);
        wreg(8'h14, 32'h0000_0500);
        pkt(1, 1, 0);
        pkt(6, 1, 0);
        expect_rd(8'h00, READY, "R4 latched steps");
        expect_rd(8'h34, rpt(1, 1, 6, 1), "R4 latched report");
        drain();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule